// File: doc/BRIEF.md
# GPIO Port with Per-Pin Resource Routing

This block is an eight-pin general purpose I/O port that sits on a simple microcontroller register bus. Each pin has a direction bit and a bit in a shared output latch. A data read returns a mixed value: input pins give their synchronized pad level and output pins give their latched drive level. Every pad input passes through a two-flop synchronizer before anything inside the block uses it.

Each pin also owns a 3-bit routing field. Through this field the pin can feed one internal resource: external interrupt 0 or 1 with either polarity, or the gate/clock control of timer 0 or timer 1. The block delivers the resource signals with polarity already applied. When several pins select the same resource, their contributions are ORed. Edge or level detection and the timers themselves lie outside the block. After reset every pin is an input with its pull-up enabled. The pull-ups remain on until software first writes the direction register.

Top module: `gpio_route_port`

## Requirements
- R1: After reset the direction register reads 0xFF, so all `pad_oe` bits are 0. All routing fields read 0, `pad_pu` is 0xFF, and all four resource outputs are 0.
- R2: Direction bit value 1 makes the pin an input and value 0 makes it an output. `pad_oe[i]` equals the inverse of direction bit i, starting the cycle after the write to address 0x91.
- R3: `pad_pu` stays 0xFF through writes to any other address. It drops to 0x00 the cycle after the first write to the direction register and stays at 0x00 until reset.
- R4: A write to address 0x90 loads the output latch, which drives `pad_out`. A read of 0x90 returns the synchronized pad level for input pins and the latch bit for output pins.
- R5: A change on `pad_in` is seen by reads and routing after exactly two rising clock edges, and not after one.
- R6: The routing registers are at 0x92 to 0x95. Register k holds the field for pin 2k in bits [2:0] and the field for pin 2k+1 in bits [5:3]. Bits [7:6] read 0, and `bus_rdata` is combinational on `bus_addr`.
- R7: Field value 2 routes the pin value, active high, to `irq0_req`. Field value 3 does the same to `irq1_req`.
- R8: Field value 4 routes the inverted pin value to `irq0_req`. Field value 5 does the same to `irq1_req`.
- R9: Field value 6 drives `tmr0_ctl` and field value 7 drives `tmr1_ctl`, both with the pin value. Field values 0 and 1 route nothing.
- R10: A resource output is the OR of the contributions of every pin that selects it, including pins that select it with opposite polarities.
- R11: A pin set as an output feeds its selected resource with its latched drive value, not with its pad input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Pad output enable, 1 means drive |
| pad_out | output | 8 | Pad output levels |
| pad_pu | output | 8 | Pad pull-up enable |
| irq0_req | output | 1 | Polarity-adjusted request for interrupt 0 |
| irq1_req | output | 1 | Polarity-adjusted request for interrupt 1 |
| tmr0_ctl | output | 1 | Gate/clock control for timer 0 |
| tmr1_ctl | output | 1 | Gate/clock control for timer 1 |

## Verification
Two functions meet on one resource when one pin selects interrupt 0 active high and another selects it active low. The OR then holds the request high in most pad patterns. The bench routes two pins this way and steps the pads through several patterns, and it expects a low request only when both contributions are inactive. A second collision comes when a direction write turns a routed pin into an output. In the next cycle its source changes from the synchronized pad to the latch, and the bench judges this by setting the latch and the pad to opposite levels.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

    parameter int unsigned BUS_AW = 8;
    parameter int unsigned BUS_DW = 8;
    parameter int unsigned SEL_W  = 3;

    localparam logic [BUS_AW-1:0] ADDR_DATA   = 8'h90;
    localparam logic [BUS_AW-1:0] ADDR_DIR    = 8'h91;
    localparam logic [BUS_AW-1:0] ADDR_ROUTE0 = 8'h92;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE_A = 3'd0,
        SEL_NONE_B = 3'd1,
        SEL_I0_HI  = 3'd2,
        SEL_I1_HI  = 3'd3,
        SEL_I0_LO  = 3'd4,
        SEL_I1_LO  = 3'd5,
        SEL_TMR0   = 3'd6,
        SEL_TMR1   = 3'd7
    } route_sel_e;

    typedef struct packed {
        logic irq0;
        logic irq1;
        logic tmr0;
        logic tmr1;
    } res_vec_t;

    function automatic res_vec_t pin_contrib(route_sel_e sel, logic level);
        res_vec_t r;
        r = '0;
        case (sel)
            SEL_I0_HI: r.irq0 = level;
            SEL_I1_HI: r.irq1 = level;
            SEL_I0_LO: r.irq0 = ~level;
            SEL_I1_LO: r.irq1 = ~level;
            SEL_TMR0:  r.tmr0 = level;
            SEL_TMR1:  r.tmr1 = level;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_route_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [BUS_DW-1:0]           bus_wdata,
    input  logic [NPIN-1:0]             pin_val,
    output logic [BUS_DW-1:0]           bus_rdata,
    output logic [NPIN-1:0]             dir_q,
    output logic [NPIN-1:0]             out_q,
    output logic                        pu_armed,
    output logic [NPIN-1:0][SEL_W-1:0]  sel_q
);
    localparam int unsigned NROUTE = NPIN / 2;

    logic wr_data, wr_dir;
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_dir  = bus_wr && (bus_addr == ADDR_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '1;
            out_q    <= '0;
            pu_armed <= 1'b1;
        end else begin
            if (wr_data) out_q <= bus_wdata[NPIN-1:0];
            if (wr_dir) begin
                dir_q    <= bus_wdata[NPIN-1:0];
                pu_armed <= 1'b0;
            end
        end
    end

    generate
        for (genvar k = 0; k < NROUTE; k++) begin : g_route
            logic hit;
            assign hit = bus_wr && (bus_addr == BUS_AW'(ADDR_ROUTE0 + k));
            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q[2*k]   <= '0;
                    sel_q[2*k+1] <= '0;
                end else if (hit) begin
                    sel_q[2*k]   <= bus_wdata[SEL_W-1:0];
                    sel_q[2*k+1] <= bus_wdata[2*SEL_W-1:SEL_W];
                end
            end
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_DATA) begin
            bus_rdata[NPIN-1:0] = pin_val;
        end else if (bus_addr == ADDR_DIR) begin
            bus_rdata[NPIN-1:0] = dir_q;
        end else begin
            for (int k = 0; k < NROUTE; k++) begin
                if (bus_addr == BUS_AW'(ADDR_ROUTE0 + k)) begin
                    bus_rdata[SEL_W-1:0]       = sel_q[2*k];
                    bus_rdata[2*SEL_W-1:SEL_W] = sel_q[2*k+1];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_router.sv
module gpio_router
    import gpio_route_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input  logic [NPIN-1:0][SEL_W-1:0] sel,
    input  logic [NPIN-1:0]            pin_val,
    output res_vec_t                   res
);
    logic [NPIN-1:0] c_irq0, c_irq1, c_tmr0, c_tmr1;

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            res_vec_t c;
            assign c         = pin_contrib(route_sel_e'(sel[i]), pin_val[i]);
            assign c_irq0[i] = c.irq0;
            assign c_irq1[i] = c.irq1;
            assign c_tmr0[i] = c.tmr0;
            assign c_tmr1[i] = c.tmr1;
        end
    endgenerate

    assign res.irq0 = |c_irq0;
    assign res.irq1 = |c_irq1;
    assign res.tmr0 = |c_tmr0;
    assign res.tmr1 = |c_tmr1;
endmodule

// File: rtl/gpio_route_port.sv
module gpio_route_port
    import gpio_route_pkg::*;
#(
    parameter int unsigned NPIN        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_pu,
    output logic              irq0_req,
    output logic              irq1_req,
    output logic              tmr0_ctl,
    output logic              tmr1_ctl
);
    logic [NPIN-1:0]            pad_sync;
    logic [NPIN-1:0]            dir_q;
    logic [NPIN-1:0]            out_q;
    logic [NPIN-1:0]            pin_val;
    logic [NPIN-1:0][SEL_W-1:0] sel_q;
    logic                       pu_armed;
    res_vec_t                   res;

    gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    assign pin_val = (dir_q & pad_sync) | (~dir_q & out_q);

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_val   (pin_val),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .pu_armed  (pu_armed),
        .sel_q     (sel_q)
    );

    gpio_router #(.NPIN(NPIN)) u_router (
        .sel     (sel_q),
        .pin_val (pin_val),
        .res     (res)
    );

    assign pad_oe   = ~dir_q;
    assign pad_out  = out_q;
    assign pad_pu   = {NPIN{pu_armed}};
    assign irq0_req = res.irq0;
    assign irq1_req = res.irq1;
    assign tmr0_ctl = res.tmr0;
    assign tmr1_ctl = res.tmr1;
endmodule

// File: rtl/gpio_route_chk.sv
module gpio_route_chk #(
    parameter int unsigned NPIN = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_wdata,
    input logic [NPIN-1:0]      pad_oe,
    input logic [NPIN-1:0]      pad_out,
    input logic [NPIN-1:0]      pad_pu,
    input logic                 irq0_req,
    input logic                 irq1_req,
    input logic                 tmr0_ctl,
    input logic                 tmr1_ctl,
    input logic [NPIN*3-1:0]    sel_q
);
    // R1: state one cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_pu == '1 &&
                 !irq0_req && !irq1_req && !tmr0_ctl && !tmr1_ctl));

    // R2: direction write sets output enables to the inverse
    a_r2_dir_oe: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h91) |=> (pad_oe == ~$past(bus_wdata[NPIN-1:0])));

    // R3: first direction write drops pull-ups
    a_r3_pu_drop: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h91) |=> (pad_pu == '0));

    // R3: once off, pull-ups stay off
    a_r3_pu_stays_off: assert property (@(posedge clk) disable iff (rst)
        (pad_pu == '0) |=> (pad_pu == '0));

    // R3: pull-ups are all on or all off
    a_r3_pu_uniform: assert property (@(posedge clk) disable iff (rst)
        (pad_pu == '0 || pad_pu == '1));

    // R4: data write loads the driven levels
    a_r4_out_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h90) |=> (pad_out == $past(bus_wdata[NPIN-1:0])));

    // R9: with no routing active, all resources are idle
    a_r9_no_route_idle: assert property (@(posedge clk) disable iff (rst)
        (sel_q == '0) |-> (!irq0_req && !irq1_req && !tmr0_ctl && !tmr1_ctl));
endmodule

bind gpio_route_port gpio_route_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .irq0_req  (irq0_req),
    .irq1_req  (irq1_req),
    .tmr0_ctl  (tmr0_ctl),
    .tmr1_ctl  (tmr1_ctl),
    .sel_q     (sel_q)
);

// File: tb/sim_gpio_route_port.sv
module sim_gpio_route_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic       irq0_req, irq1_req, tmr0_ctl, tmr1_ctl;

    always #2.5 clk = ~clk;

    gpio_route_port u0 (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .irq0_req(irq0_req), .irq1_req(irq1_req),
        .tmr0_ctl(tmr0_ctl), .tmr1_ctl(tmr1_ctl)
    );

    // kinds: 0 rdata, 1 {irq0,irq1,tmr0,tmr1}, 2 pad_oe, 3 pad_pu, 4 pad_out
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {4'b0, irq0_req, irq1_req, tmr0_ctl, tmr1_ctl};
                2:       act = pad_oe;
                3:       act = pad_pu;
                default: act = pad_out;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] e, input string req);
        sb_item_t it;
        it.kind = kind; it.exp = e; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
        bus_addr = a;
        expect_item(0, e, req);
        tick();
    endtask

    task automatic chk(input int kind, input logic [7:0] e, input string req);
        expect_item(kind, e, req);
        tick();
    endtask

    // res nibble: {irq0, irq1, tmr0, tmr1}
    initial begin
        ticks(3);
        rst = 1'b0;
        tick();

        // R1 reset state
        rd_chk(8'h91, 8'hFF, "R1 dir reset");
        chk(2, 8'h00, "R1 pad_oe reset");
        chk(3, 8'hFF, "R1 pad_pu reset");
        chk(1, 8'h00, "R1 resources reset");
        rd_chk(8'h92, 8'h00, "R1 route0 reset");
        rd_chk(8'h95, 8'h00, "R1 route3 reset");

        // R5 two-edge synchronizer latency
        pad_in = 8'hA5;
        tick();
        rd_chk(8'h90, 8'h00, "R5 not after one edge");
        rd_chk(8'h90, 8'hA5, "R5 seen after two edges");

        // R6 field layout, unused bits read 0
        wr(8'h92, 8'hFF);
        rd_chk(8'h92, 8'h3F, "R6 upper bits read 0");
        chk(3, 8'hFF, "R3 pull-ups kept after route write");

        // R7 active-high: pin0 sel2 (pin0=1), pin1 sel3 (pin1=0)
        wr(8'h92, 8'h1A);
        rd_chk(8'h92, 8'h1A, "R6 route0 readback");
        chk(1, 8'b1000, "R7 active high");

        // R8 inverted: pin2 sel4 (pin2=1), pin3 sel5 (pin3=0)
        wr(8'h92, 8'h00);
        wr(8'h93, 8'h2C);
        rd_chk(8'h93, 8'h2C, "R6 route1 readback");
        chk(1, 8'b0100, "R8 active low");

        // R9 timers: pin4 sel6 (0), pin5 sel7 (1)
        wr(8'h93, 8'h00);
        wr(8'h94, 8'h3E);
        chk(1, 8'b0001, "R9 timers A");
        pad_in = 8'h10;
        ticks(2);
        chk(1, 8'b0010, "R9 timers B");
        // R9 sel 0/1 route nothing
        wr(8'h94, 8'h00);
        wr(8'h95, 8'h08);
        pad_in = 8'hFF;
        ticks(2);
        chk(1, 8'b0000, "R9 select 0 and 1 idle");
        wr(8'h95, 8'h00);

        // R10 OR merge: pin0 and pin1 both sel2
        wr(8'h92, 8'h12);
        pad_in = 8'h01; ticks(2);
        chk(1, 8'b1000, "R10 or via pin0");
        pad_in = 8'h02; ticks(2);
        chk(1, 8'b1000, "R10 or via pin1");
        pad_in = 8'h00; ticks(2);
        chk(1, 8'b0000, "R10 both low");
        // opposite polarities: pin0 sel2, pin1 sel4
        wr(8'h92, 8'h22);
        chk(1, 8'b1000, "R10 mixed pin1 inverted low");
        pad_in = 8'h02; ticks(2);
        chk(1, 8'b0000, "R10 mixed both inactive");
        pad_in = 8'h03; ticks(2);
        chk(1, 8'b1000, "R10 mixed pin0 high");
        wr(8'h92, 8'h00);

        // R2 / R3 direction write
        wr(8'h91, 8'hF0);
        chk(2, 8'h0F, "R2 pad_oe");
        chk(3, 8'h00, "R3 pull-ups off");
        rd_chk(8'h91, 8'hF0, "R2 dir readback");
        wr(8'h91, 8'hF0);
        chk(3, 8'h00, "R3 pull-ups stay off");

        // R4 mixed data read
        wr(8'h90, 8'h3C);
        chk(4, 8'h3C, "R4 pad_out");
        pad_in = 8'hA0; ticks(2);
        rd_chk(8'h90, 8'hAC, "R4 mixed read");

        // R11 output pin routes its driven value: pin0 output, latch 0, pad 1
        pad_in = 8'hFF; ticks(2);
        wr(8'h92, 8'h02);
        chk(1, 8'b0000, "R11 driven low despite pad high");
        wr(8'h90, 8'h01);
        chk(1, 8'b1000, "R11 driven high");
        // switch pin0 back to input: pad level now used
        wr(8'h91, 8'hF1);
        chk(1, 8'b1000, "R11 input uses pad");
        wr(8'h90, 8'h00);
        chk(1, 8'b1000, "R11 input ignores latch");

        ticks(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule